// File: doc/BRIEF.md
# Hot-Plug Slot Command Executor

This block executes the 16-bit commands that software writes to a hot-plug controller. A command word names an opcode and a one-based target slot. The block works out what the command means, holds a busy flag while the command is in progress, and then commits the result. A result can be a new slot state, new power and attention indicator settings, a new bus speed/mode code, or an error flag.

Actual power sequencing, indicator blinking and bus clock changes belong to other logic. Here the time a command takes is modelled by a fixed count of `EXEC_CYCLES` clock cycles. When that count expires, busy drops and a one-cycle completion event goes to the interrupt logic.

The status nibble has four bits. Bit 0 is busy. Bits 1, 2 and 3 report, for the last command, a latch-open refusal, an invalid command and an invalid speed/mode.

Top module: `hp_cmd_exec`

## Requirements
- R1: After reset, every slot state field reads 3 (disabled) and every power and attention indicator field reads 3 (off). The speed/mode code is 0 and the status nibble is 0.
- R2: A write with busy low is accepted. Status bit 0 (busy) is high from the next cycle for exactly `EXEC_CYCLES` cycles. `cmd_done` is high for one cycle, in the first cycle in which busy is low again.
- R3: A write while busy is low is the only kind accepted. A write made while busy is high changes no output and does not lengthen the current command.
- R4: The command word holds the opcode in bits 7:0 and the target slot in bits 15:8, where slot 1 is the first. Opcodes 00h to 3Fh are slot operations that act on three fields:
  - opcode bits 1:0 set the slot state (1 power-only, 2 enabled, 3 disabled);
  - opcode bits 3:2 set the power indicator (1 on, 2 blink, 3 off);
  - opcode bits 5:4 set the attention indicator, with the same encoding as the power indicator;
  - a field value of 0 leaves that item unchanged.
- R5: A slot operation whose state field is 1 or 2 is refused when the target slot's `mrl_open` bit is high at completion. The refusal sets status bit 1 and leaves all three fields of that slot unchanged.
- R6: Some commands set status bit 2 and change nothing:
  - a slot operation with target 0;
  - a slot operation with a target above `NSLOTS`;
  - an opcode of 40h or above with a nonzero target.
- R7: At target 0, opcodes 40h to 44h set the speed/mode code to the opcode minus 40h. Opcodes 45h to 47h set status bit 3 and leave the code unchanged.
- R8: At target 0, opcodes 50h to 5Dh set the speed/mode code to the opcode minus 50h when `pi_level` is 2. When `pi_level` is not 2, these opcodes set status bit 3 instead. Opcodes 5Eh and 5Fh always set status bit 3.
- R9: At target 0, opcode 48h sets every slot with its latch closed to state 1, and opcode 49h sets every such slot to state 2. A slot with its latch open keeps its state, and its presence sets status bit 1.
- R10: At target 0, opcodes 4Ah to 4Fh and 60h to FFh set status bit 2 and change nothing.
- R11: In the cycle busy rises, status bits 3:1 read 0, whatever the previous command left there.
- R12: Commands that end in an error still run the full busy period and still pulse `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: target slot in 15:8, opcode in 7:0 |
| pi_level | input | 2 | Programming-interface level (1 or 2) |
| mrl_open | input | NSLOTS | Per-slot retention latch open |
| status | output | 4 | {speed error, invalid command, latch-open error, busy} |
| cmd_done | output | 1 | One-cycle command completion event |
| speed_mode | output | 4 | Current bus speed/mode code |
| slot_state | output | 2*NSLOTS | Per-slot state, slot 1 in bits 1:0 |
| pwr_ind | output | 2*NSLOTS | Per-slot power indicator |
| attn_ind | output | 2*NSLOTS | Per-slot attention indicator |

## Verification
Suppose the latched opcode or target is wrong, or the decode takes the wrong branch. Then the wrong slot field, speed code or error bit appears in the very cycle that `cmd_done` pulses, so every command's result is compared at that single cycle. A bad busy counter shows at once as a busy period of the wrong length or a missing completion pulse. The sweep covers every opcode against targets 0 to `NSLOTS`+1 at both interface levels, with latch patterns that vary from command to command.

// File: rtl/hp_cmd_exec.sv
module hp_cmd_exec #(
  parameter int NSLOTS      = 4,
  parameter int EXEC_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic [15:0]         cmd_data,
  input  logic [1:0]          pi_level,
  input  logic [NSLOTS-1:0]   mrl_open,
  output logic [3:0]          status,
  output logic                cmd_done,
  output logic [3:0]          speed_mode,
  output logic [2*NSLOTS-1:0] slot_state,
  output logic [2*NSLOTS-1:0] pwr_ind,
  output logic [2*NSLOTS-1:0] attn_ind
);
  localparam int CW = (EXEC_CYCLES > 1) ? $clog2(EXEC_CYCLES) : 1;

  logic              busy, done_q;
  logic [CW-1:0]     cnt;
  logic [7:0]        op_q, tgt_q;
  logic [2:0]        err_q, err_n;
  logic [3:0]        spd_q, spd_n;
  logic [2*NSLOTS-1:0] st_q, pw_q, at_q, st_n, pw_n, at_n;

  wire accept = cmd_wr && !busy;
  wire lvl2   = (pi_level == 2'd2);
  wire finish = busy && (cnt == '0);

  always_comb begin
    st_n  = st_q;
    pw_n  = pw_q;
    at_n  = at_q;
    spd_n = spd_q;
    err_n = '0;
    if (op_q < 8'h40) begin
      if (tgt_q == 8'd0 || tgt_q > 8'(NSLOTS)) begin
        err_n[1] = 1'b1;
      end else begin
        for (int s = 0; s < NSLOTS; s++) begin
          if (tgt_q == 8'(s + 1)) begin
            if ((op_q[1:0] == 2'd1 || op_q[1:0] == 2'd2) && mrl_open[s]) begin
              err_n[0] = 1'b1;
            end else begin
              if (op_q[1:0] != 2'd0) st_n[2*s +: 2] = op_q[1:0];
              if (op_q[3:2] != 2'd0) pw_n[2*s +: 2] = op_q[3:2];
              if (op_q[5:4] != 2'd0) at_n[2*s +: 2] = op_q[5:4];
            end
          end
        end
      end
    end else if (tgt_q != 8'd0) begin
      err_n[1] = 1'b1;
    end else if (op_q <= 8'h44) begin
      spd_n = {1'b0, op_q[2:0]};
    end else if (op_q <= 8'h47) begin
      err_n[2] = 1'b1;
    end else if (op_q == 8'h48 || op_q == 8'h49) begin
      for (int s = 0; s < NSLOTS; s++) begin
        if (mrl_open[s]) err_n[0] = 1'b1;
        else st_n[2*s +: 2] = op_q[0] ? 2'd2 : 2'd1;
      end
    end else if (op_q < 8'h50) begin
      err_n[1] = 1'b1;
    end else if (op_q <= 8'h5D) begin
      if (lvl2) spd_n = op_q[3:0];
      else      err_n[2] = 1'b1;
    end else if (op_q <= 8'h5F) begin
      err_n[2] = 1'b1;
    end else begin
      err_n[1] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
      op_q   <= '0;
      tgt_q  <= '0;
      err_q  <= '0;
      spd_q  <= '0;
      st_q   <= {NSLOTS{2'd3}};
      pw_q   <= {NSLOTS{2'd3}};
      at_q   <= {NSLOTS{2'd3}};
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        cnt   <= CW'(EXEC_CYCLES - 1);
        op_q  <= cmd_data[7:0];
        tgt_q <= cmd_data[15:8];
        err_q <= '0;
      end else if (finish) begin
        busy   <= 1'b0;
        done_q <= 1'b1;
        st_q   <= st_n;
        pw_q   <= pw_n;
        at_q   <= at_n;
        spd_q  <= spd_n;
        err_q  <= err_n;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign status     = {err_q, busy};
  assign cmd_done   = done_q;
  assign speed_mode = spd_q;
  assign slot_state = st_q;
  assign pwr_ind    = pw_q;
  assign attn_ind   = at_q;

  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> (!busy && $past(busy)));
  // R12
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cmd_done);
  // R11
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (status[3:1] == 3'b000));
  // R4
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_done |-> ($stable(slot_state) && $stable(pwr_ind) && $stable(attn_ind)));
  // R7
  speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_done |-> $stable(speed_mode));
  // R6
  one_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status[3:1]) <= 1);
  // R8
  speed_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    speed_mode <= 4'hD);
endmodule

// File: tb/tb_hp_cmd_exec.sv
module tb_hp_cmd_exec;
  localparam int N = 4;
  localparam int E = 3;

  logic clk = 0, rst_n = 0, cmd_wr = 0;
  logic [15:0] cmd_data = '0;
  logic [1:0] pi_level = 2'd1;
  logic [N-1:0] mrl_open = '0;
  logic [3:0] status, speed_mode;
  logic cmd_done;
  logic [2*N-1:0] slot_state, pwr_ind, attn_ind;

  hp_cmd_exec #(.NSLOTS(N), .EXEC_CYCLES(E)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [2*N-1:0] e_st = {N{2'd3}}, e_pw = {N{2'd3}}, e_at = {N{2'd3}};
  logic [3:0] e_spd = 0;
  logic [2:0] e_err = 0;
  string tag;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] op, input logic [7:0] tgt);
    e_err = 0;
    if (op < 8'h40) begin
      if (tgt == 0 || tgt > N) begin e_err = 3'b010; tag = "R6"; end
      else begin
        int s = tgt - 1;
        if ((op[1:0] == 1 || op[1:0] == 2) && mrl_open[s]) begin e_err = 3'b001; tag = "R5"; end
        else begin
          tag = "R4";
          if (op[1:0] != 0) e_st[2*s +: 2] = op[1:0];
          if (op[3:2] != 0) e_pw[2*s +: 2] = op[3:2];
          if (op[5:4] != 0) e_at[2*s +: 2] = op[5:4];
        end
      end
    end else if (tgt != 0) begin e_err = 3'b010; tag = "R6"; end
    else if (op <= 8'h44) begin e_spd = 4'(op - 8'h40); tag = "R7"; end
    else if (op <= 8'h47) begin e_err = 3'b100; tag = "R7"; end
    else if (op == 8'h48 || op == 8'h49) begin
      tag = "R9";
      for (int s = 0; s < N; s++)
        if (mrl_open[s]) e_err = 3'b001;
        else e_st[2*s +: 2] = (op == 8'h49) ? 2'd2 : 2'd1;
    end else if (op < 8'h50) begin e_err = 3'b010; tag = "R10"; end
    else if (op <= 8'h5D) begin
      tag = "R8";
      if (pi_level == 2) e_spd = 4'(op - 8'h50); else e_err = 3'b100;
    end else if (op <= 8'h5F) begin e_err = 3'b100; tag = "R8"; end
    else begin e_err = 3'b010; tag = "R10"; end
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [7:0] tgt, input bit poke);
    int n;
    @(negedge clk);
    cmd_data = {tgt, op};
    cmd_wr = 1;
    @(negedge clk);
    cmd_wr = 0;
    chk(status[0] == 1'b1, "R2", status, 1);
    chk(status[3:1] == 3'b000, "R11", status, 0);
    if (poke) begin
      cmd_data = 16'h0103;
      cmd_wr = 1;
    end
    n = 0;
    while (status[0] && n < 50) begin
      n++;
      @(negedge clk);
      cmd_wr = 0;
    end
    chk(n == E, "R2", n, E);
    chk(cmd_done == 1'b1, "R12", cmd_done, 1);
    model(op, tgt);
    chk(status[3:1] == e_err, tag, status, {e_err, 1'b0});
    chk(slot_state == e_st && pwr_ind == e_pw && attn_ind == e_at, tag,
        {slot_state, pwr_ind, attn_ind}, {e_st, e_pw, e_at});
    chk(speed_mode == e_spd, tag, speed_mode, e_spd);
    @(negedge clk);
    chk(cmd_done == 1'b0, "R2", cmd_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(slot_state == {N{2'd3}} && pwr_ind == {N{2'd3}} && attn_ind == {N{2'd3}}, "R1",
        {slot_state, pwr_ind, attn_ind}, {3{{N{2'd3}}}});
    chk(speed_mode == 0 && status == 0 && cmd_done == 0, "R1", {speed_mode, status}, 0);
    // R3: write during busy (disable slot 1) must be ignored
    mrl_open = '0;
    run_cmd(8'h16, 8'd2, 1'b1);
    chk(slot_state[1:0] == 2'd3, "R3", slot_state, e_st);
    run_cmd(8'h02, 8'd1, 1'b0);
    run_cmd(8'h03, 8'd1, 1'b1);
    chk(slot_state[1:0] == 2'd3, "R3", slot_state[1:0], 3);
    // R5 latch open refusal, then R11 error cleared by next command
    mrl_open = 4'b0100;
    run_cmd(8'h3A, 8'd3, 1'b0);
    run_cmd(8'h49, 8'd0, 1'b0);
    mrl_open = 0;
    run_cmd(8'h40, 8'd0, 1'b0);
    // sweep all opcodes, targets and levels
    for (int lv = 1; lv <= 2; lv++)
      for (int t = 0; t <= N + 1; t++)
        for (int op = 0; op < 256; op++) begin
          pi_level = 2'(lv);
          mrl_open = 4'((op * 7 + t * 3) >> 2);
          run_cmd(8'(op), 8'(t), 1'b0);
        end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule